// File: doc/BRIEF.md
# Eight-bit Timer with Two Compare Channels

This block is an 8-bit count register. It advances on a timer-tick enable that is chosen from a vector of tick sources. A 3-bit select field picks the source, and select value zero halts the count. A two-bit mode field sets the counting sequence:

- free-running up-count with wrap,
- up-count that clears after matching compare value A,
- triangular up/down count.

Two equality comparators watch the count against compare values A and B. Three sticky flags record events:

- overflow,
- compare-A match,
- compare-B match.

Each flag is gated with its enable bit to form an interrupt request. Each flag clears when software writes a one to it or when its request is acknowledged.

Software reaches every field through a small word-wide register port. Reads are registered: `reg_rdata` shows, one cycle later, the register selected by `reg_addr` as it stood before that edge. A write to the count register beats any count or clear operation in the same cycle.

Top module: `tmr8_dual_cmp`

## Requirements
- R1: A tick occurs in a cycle when the select field is nonzero and bit `tick_src[select]` is high. Bit 0 of `tick_src` is never used. In free-running mode each tick adds one to the count.
- R2: With select zero the count holds its value. The count register (address 1) is still readable and writable.
- R3: A write to the count register sets the count to the written value at that edge, even if a tick falls in the same cycle.
- R4: In free-running mode (mode code 0, and also reserved code 3), a tick at count 255 wraps the count to 0 and sets the overflow flag (flag bit 0).
- R5: In clear-on-match mode (mode code 1), a tick while the count equals compare A loads 0. Otherwise the tick adds one. The overflow flag is never set in this mode.
- R6: In up/down mode (mode code 2), the count runs 0,1,…,255,254,…,1,0,1,… Neither extreme repeats. The overflow flag is set by the tick that brings the count down to 0.
- R7: A tick while the count equals compare A (address 2) sets flag bit 1. A tick while the count equals compare B (address 3) sets flag bit 2. The flag becomes visible after that tick's edge.
- R8: Writing a one to a bit of the flag register (address 5) clears that flag. Pulsing `irq_ack[i]` clears flag i. Writing a zero has no effect. A hardware set in the same cycle as a clear wins.
- R9: `irq[i]` is high exactly when flag i and enable bit i of the enable register (address 4) are both set.
- R10: `cnt_top` is high when the count is 255. `cnt_bottom` is high when the count is 0.
- R11: The control register (address 0) holds the select in bits 2:0 and the mode in bits 4:3. Addresses 6 and 7 read as zero. After reset every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_src | input | 8 | Candidate tick enables, indexed by the select field |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| irq_ack | input | 3 | Per-flag acknowledge (0 overflow, 1 compare A, 2 compare B) |
| irq | output | 3 | Per-flag interrupt request |
| cnt_top | output | 1 | Count equals 255 |
| cnt_bottom | output | 1 | Count equals 0 |

## Verification
The properties assume that the mode field holds one of its four codes. They also assume that a tick is judged from the select value held in the cycle itself, so a control write changes the tick source only from the next cycle. The up/down turn property additionally assumes the count was not loaded by software in that cycle, and it is gated on that load. The stimulus drives every select value, including zero and sources that toggle or are random. It changes mode only through register writes at negative edges, and it deliberately lines up count loads and flag clears with ticks and matches, so that the priority cases occur.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_AW = 3;
  localparam int NFLAG  = 3;

  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_COUNT = 3'd1;
  localparam logic [REG_AW-1:0] A_CMPA  = 3'd2;
  localparam logic [REG_AW-1:0] A_CMPB  = 3'd3;
  localparam logic [REG_AW-1:0] A_IEN   = 3'd4;
  localparam logic [REG_AW-1:0] A_FLAGS = 3'd5;

  localparam int FL_OVF = 0;
  localparam int FL_CA  = 1;
  localparam int FL_CB  = 2;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_CTC  = 2'd1,
    MODE_UPDN = 2'd2,
    MODE_RSV  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int SELW = 3
) (
  input  logic [SELW-1:0]      sel,
  input  logic [(1<<SELW)-1:0] src,
  output logic                 tick
);
  // Select code zero means "no source"; bit 0 of src is never used.
  assign tick = (sel != '0) && src[sel];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  tmr_mode_e    mode,
  input  logic [W-1:0] clr_val,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         ovf_evt,
  output logic         at_top,
  output logic         at_bot
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, nxt;
  logic         up_q, eff_up;

  always_comb begin
    eff_up  = up_q;
    nxt     = cnt_q;
    ovf_evt = 1'b0;
    case (mode)
      MODE_CTC: begin
        eff_up = 1'b1;
        nxt    = (cnt_q == clr_val) ? '0 : cnt_q + ONE;
      end
      MODE_UPDN: begin
        if (cnt_q == MAXV)    eff_up = 1'b0;
        else if (cnt_q == '0) eff_up = 1'b1;
        nxt     = eff_up ? cnt_q + ONE : cnt_q - ONE;
        ovf_evt = tick && !eff_up && (cnt_q == ONE);
      end
      default: begin
        eff_up  = 1'b1;
        nxt     = cnt_q + ONE;
        ovf_evt = tick && (cnt_q == MAXV);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      if (mode != MODE_UPDN) up_q <= 1'b1;
      else if (tick)         up_q <= eff_up;
      if (ld)        cnt_q <= ld_val;
      else if (tick) cnt_q <= nxt;
    end
  end

  assign cnt    = cnt_q;
  assign at_top = (cnt_q == MAXV);
  assign at_bot = (cnt_q == '0);
endmodule

// File: rtl/tmr_flag_bit.sv
module tmr_flag_bit (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/tmr8_dual_cmp.sv
module tmr8_dual_cmp
  import tmr_pkg::*;
#(
  parameter int W   = 8,
  parameter int CSW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [(1<<CSW)-1:0]  tick_src,
  input  logic                 reg_wr,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [W-1:0]         reg_wdata,
  output logic [W-1:0]         reg_rdata,
  input  logic [NFLAG-1:0]     irq_ack,
  output logic [NFLAG-1:0]     irq,
  output logic                 cnt_top,
  output logic                 cnt_bottom
);
  localparam int MODE_LSB = CSW;
  localparam int MODE_MSB = CSW + 1;

  logic [CSW-1:0]   cs_q;
  tmr_mode_e        mode_q;
  logic [W-1:0]     cmpa_q, cmpb_q, cnt;
  logic [NFLAG-1:0] ien_q, flags, fl_set, fl_clr;
  logic             tick, ovf_evt;
  logic             wr_ctrl, wr_cnt, wr_ca, wr_cb, wr_ien, wr_fl;
  logic [W-1:0]     rd_mux;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_cnt  = reg_wr && (reg_addr == A_COUNT);
  assign wr_ca   = reg_wr && (reg_addr == A_CMPA);
  assign wr_cb   = reg_wr && (reg_addr == A_CMPB);
  assign wr_ien  = reg_wr && (reg_addr == A_IEN);
  assign wr_fl   = reg_wr && (reg_addr == A_FLAGS);

  tmr_tick_sel #(.SELW(CSW)) u_tick (
    .sel (cs_q),
    .src (tick_src),
    .tick(tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .mode   (mode_q),
    .clr_val(cmpa_q),
    .ld     (wr_cnt),
    .ld_val (reg_wdata),
    .cnt    (cnt),
    .ovf_evt(ovf_evt),
    .at_top (cnt_top),
    .at_bot (cnt_bottom)
  );

  assign fl_set[FL_OVF] = ovf_evt;
  assign fl_set[FL_CA]  = tick && (cnt == cmpa_q);
  assign fl_set[FL_CB]  = tick && (cnt == cmpb_q);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign fl_clr[i] = irq_ack[i] || (wr_fl && reg_wdata[i]);
    tmr_flag_bit u_fl (
      .clk(clk),
      .rst(rst),
      .set(fl_set[i]),
      .clr(fl_clr[i]),
      .q  (flags[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= '0;
      mode_q <= MODE_FREE;
      cmpa_q <= '0;
      cmpb_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        cs_q   <= reg_wdata[CSW-1:0];
        mode_q <= tmr_mode_e'(reg_wdata[MODE_MSB:MODE_LSB]);
      end
      if (wr_ca)  cmpa_q <= reg_wdata;
      if (wr_cb)  cmpb_q <= reg_wdata;
      if (wr_ien) ien_q  <= reg_wdata[NFLAG-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[CSW-1:0]         = cs_q;
        rd_mux[MODE_MSB:MODE_LSB] = mode_q;
      end
      A_COUNT: rd_mux = cnt;
      A_CMPA:  rd_mux = cmpa_q;
      A_CMPB:  rd_mux = cmpb_q;
      A_IEN:   rd_mux[NFLAG-1:0] = ien_q;
      A_FLAGS: rd_mux[NFLAG-1:0] = flags;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign irq = flags & ien_q;
endmodule

// File: rtl/tmr8_dual_cmp_chk.sv
module tmr8_dual_cmp_chk
  import tmr_pkg::*;
#(
  parameter int W   = 8,
  parameter int CSW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input tmr_mode_e        mode_q,
  input logic [CSW-1:0]   cs_q,
  input logic [W-1:0]     cnt,
  input logic [W-1:0]     cmpa_q,
  input logic [NFLAG-1:0] flags,
  input logic             reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [W-1:0]     reg_wdata
);
  localparam logic [W-1:0] MAXV = '1;
  logic cw;
  assign cw = reg_wr && (reg_addr == A_COUNT);

  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    cw |=> (cnt == $past(reg_wdata))); // R3
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cs_q == '0 && !cw) |=> $stable(cnt)); // R2
  AST_FREE_WRAP_OVF: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_FREE && tick && cnt == MAXV) |=> flags[FL_OVF]); // R4
  AST_CTC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_CTC && tick && cnt == cmpa_q && !cw) |=> (cnt == '0)); // R5
  AST_CTC_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_CTC && !flags[FL_OVF]) |=> !flags[FL_OVF]); // R5
  AST_UPDN_TURN: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_UPDN && tick && cnt == MAXV && !cw) |=> (cnt == MAXV - W'(1))); // R6
  AST_CMPA_SETS: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == cmpa_q) |=> flags[FL_CA]); // R7
endmodule

bind tmr8_dual_cmp tmr8_dual_cmp_chk #(.W(W), .CSW(CSW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .mode_q   (mode_q),
  .cs_q     (cs_q),
  .cnt      (cnt),
  .cmpa_q   (cmpa_q),
  .flags    (flags),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata)
);

// File: tb/tmr8_dual_cmp_tb.sv
module tmr8_dual_cmp_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tick_src = '0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] irq_ack = '0;
  logic [2:0] irq;
  logic       cnt_top, cnt_bottom;

  always #5 clk = ~clk;

  tmr8_dual_cmp u_dut (
    .clk(clk), .rst(rst), .tick_src(tick_src), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ack(irq_ack), .irq(irq), .cnt_top(cnt_top), .cnt_bottom(cnt_bottom)
  );

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R11";
  bit    done = 0, tog = 0;

  // Behavioural reference state
  int m_cs, m_mode, m_cnt, m_ca, m_cb, m_ien, m_fl, m_rd;
  bit m_up;

  always @(posedge clk) begin
    if (rst) begin
      m_cs = 0; m_mode = 0; m_cnt = 0; m_ca = 0; m_cb = 0;
      m_ien = 0; m_fl = 0; m_rd = 0; m_up = 1;
    end else begin
      int rdv, nx, setm, clrm;
      bit tk, upn, ovs;
      case (reg_addr)
        3'd0: rdv = m_cs + m_mode * 8;
        3'd1: rdv = m_cnt;
        3'd2: rdv = m_ca;
        3'd3: rdv = m_cb;
        3'd4: rdv = m_ien;
        3'd5: rdv = m_fl;
        default: rdv = 0;
      endcase
      tk  = (m_cs != 0) && tick_src[m_cs];
      upn = m_up; ovs = 0;
      if (m_mode == 1) begin
        upn = 1; nx = (m_cnt == m_ca) ? 0 : (m_cnt + 1) % 256;
      end else if (m_mode == 2) begin
        if (m_cnt == 255) upn = 0; else if (m_cnt == 0) upn = 1;
        nx  = upn ? m_cnt + 1 : m_cnt - 1;
        ovs = tk && !upn && m_cnt == 1;
      end else begin
        upn = 1; nx = (m_cnt + 1) % 256; ovs = tk && m_cnt == 255;
      end
      setm = (ovs ? 1 : 0) + ((tk && m_cnt == m_ca) ? 2 : 0) + ((tk && m_cnt == m_cb) ? 4 : 0);
      clrm = int'(irq_ack) | ((reg_wr && reg_addr == 3'd5) ? int'(reg_wdata) & 7 : 0);
      if (m_mode != 2) m_up = 1; else if (tk) m_up = upn;
      if (reg_wr && reg_addr == 3'd1) m_cnt = int'(reg_wdata);
      else if (tk) m_cnt = nx;
      if (reg_wr && reg_addr == 3'd0) begin
        m_cs = int'(reg_wdata) & 7; m_mode = (int'(reg_wdata) >> 3) & 3;
      end
      if (reg_wr && reg_addr == 3'd2) m_ca = int'(reg_wdata);
      if (reg_wr && reg_addr == 3'd3) m_cb = int'(reg_wdata);
      if (reg_wr && reg_addr == 3'd4) m_ien = int'(reg_wdata) & 7;
      m_fl = setm | (m_fl & ~clrm & 7);
      m_rd = rdv;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [12:0] act, exp;
      act = {reg_rdata, irq, cnt_top, cnt_bottom};
      exp = {8'(m_rd), 3'(m_fl & m_ien), m_cnt == 255, m_cnt == 0};
      n_chk++;
      if (act !== exp) begin
        n_bad++;
        $display("FAIL %s t=%0t rdata/irq/top/bot act=%h exp=%h", cur_req, $time, act, exp);
      end
    end
  end

  task automatic drive(bit wr, int a, int d, int ack);
    @(negedge clk);
    reg_wr = wr; reg_addr = 3'(a); reg_wdata = 8'(d); irq_ack = 3'(ack);
    tick_src = 8'($urandom);
    tick_src[1] = 1'b1;
    tick_src[2] = tog;
    tog = ~tog;
  endtask

  task automatic idle(int n, int a);
    for (int i = 0; i < n; i++) drive(0, a, 0, 0);
  endtask

  task automatic wr(int a, int d);
    drive(1, a, d, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL %s watchdog act=running exp=finished", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset values and register map
    cur_req = "R11";
    for (int a = 0; a < 8; a++) idle(2, a);
    wr(0, 8'h1B); idle(2, 0);
    // R1: tick select with several sources
    cur_req = "R1";
    wr(0, 1); idle(20, 1);
    wr(0, 2); idle(20, 1);
    wr(0, 5); idle(20, 1);
    wr(0, 7); idle(20, 1);
    // R2: stopped counter, still writable
    cur_req = "R2";
    wr(0, 0); idle(10, 1); wr(1, 8'h77); idle(6, 1);
    // R3: write during ticking
    cur_req = "R3";
    wr(0, 1);
    for (int i = 0; i < 5; i++) wr(1, $urandom % 256);
    idle(3, 1);
    // R4: wrap and overflow in free-running and reserved modes
    cur_req = "R4";
    wr(1, 250); idle(12, 1); idle(2, 5); wr(5, 7);
    wr(0, 8'h19); wr(1, 252); idle(8, 5); wr(5, 1);
    // R5: clear on compare A
    cur_req = "R5";
    wr(2, 20); wr(0, 8'h09); wr(1, 0); idle(50, 1); idle(3, 5);
    wr(2, 255); idle(300, 5); wr(5, 7);
    // R6: up/down triangle
    cur_req = "R6";
    wr(0, 8'h11); wr(1, 0);
    for (int i = 0; i < 300; i++) idle(2, (i % 2) ? 1 : 5);
    // R7: compare flags
    cur_req = "R7";
    wr(0, 1); wr(5, 7); wr(2, 100); wr(3, 33); wr(1, 0);
    idle(120, 5);
    // R8: clear rules and set priority
    cur_req = "R8";
    wr(5, 0); idle(2, 5); wr(5, 2); idle(2, 5);
    drive(0, 5, 0, 4); idle(2, 5);
    wr(1, 100); wr(5, 2); idle(2, 5);
    wr(1, 33); drive(0, 5, 0, 4); idle(2, 5);
    // R9: interrupt gating
    cur_req = "R9";
    wr(4, 7); wr(1, 95); idle(10, 5); wr(4, 2); idle(40, 5);
    drive(0, 4, 0, 7); idle(3, 4); wr(4, 5); idle(300, 5);
    // R10: top/bottom under random traffic
    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 8 == 0) drive(1, $urandom % 8, $urandom % 256, $urandom % 8);
      else drive(0, $urandom % 8, 0, ($urandom % 16 == 0) ? $urandom % 8 : 0);
    end
    idle(3, 1);
    done = 1;
    summary();
    $finish;
  end
endmodule